// File: doc/BRIEF.md
# DMA Read Request Splitter

This block is a single-channel copy engine that moves a block of bytes from host memory into local SRAM. Software fills in a 64-bit source address, an SRAM destination address, a byte count and a transfer mode through a small word-indexed register port. It then writes the control register with its top bit set. The engine cuts the transfer into host read requests and keeps track of how many of them are still waiting for data. It writes each returned data beat into SRAM and can raise a one-cycle interrupt when the last byte has landed.

Requests are sized from three inputs: a chunk-size selection, the current source address and an optional split rule. The split rule sends large requests only from 128-byte-aligned addresses. Otherwise it stops a request at the next 64-byte boundary. The host bus is a plain request/response model with in-order responses, and the SRAM side is a single write port with byte enables. The engine latches all settings when the start bit is written, so software may rewrite the registers during a transfer without disturbing it.

Top module: `dma_rd_splitter`

## Requirements
- R1: After reset, no request, SRAM write or interrupt is driven. Every register reads as zero, and the busy indication is clear.
- R2: Register words are selected by `reg_addr`: 0 control, 1 mode, 2 source low, 3 source high, 4 destination byte address, 5 byte count. Writing the control word with bit 31 set while idle starts a transfer. Control bits 31 and 16 both read 1 while the transfer runs and return to 0 when it completes. A start while busy is ignored.
- R3: Mode bits 9:8 select the largest request: 0 gives 64 bytes, 1 gives 128 bytes, 2 or 3 give 256 bytes. Without the split rule, each request has length min(chunk, remaining bytes), and successive requests cover contiguous addresses from the source.
- R4: With mode bit 10 set and a chunk above 64 bytes, a request starting on a 128-byte-aligned address may use the full chunk. A request starting anywhere else ends at or before the next 64-byte boundary.
- R5: Mode bits 3:0 cap the number of requests issued but not yet fully answered. Values above 12 act as 12, and 0 acts as 1.
- R6: Returned beats (4 bytes each, in order) are written to consecutive SRAM words starting at the destination word. Every beat enables all byte lanes except the final beat of a count that is not a multiple of 4, which enables only the low (count mod 4) lanes.
- R7: When control bits 25:24 equal 1 at start, `irq` pulses high for exactly one cycle as the transfer completes. Any other value produces no pulse.
- R8: A byte count of zero completes on the cycle after the start write. No request is issued, and the interrupt rule of R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RIDX_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the word at `reg_addr` |
| rq_valid | output | 1 | Host read request valid |
| rq_ready | input | 1 | Host accepts the request |
| rq_addr | output | 64 | Request byte address |
| rq_len | output | 9 | Request length in bytes (1..256) |
| rs_valid | input | 1 | Response beat valid |
| rs_data | input | DATA_W | Response beat data |
| rs_last | input | 1 | Final beat of the oldest request |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | SRAM_AW | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_be | output | DATA_W/8 | SRAM byte-lane enables |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions take the host side on trust in several respects. They assume responses arrive only for accepted requests, in acceptance order. They assume each response carries the ceiling of its length over 4 in beats, with `rs_last` marking the final one. They also assume the source and destination addresses are 4-byte aligned. The bench's host model queues every accepted request with its acceptance cycle and replays exactly that beat count after a chosen latency. It never answers ahead of the queue, and every scenario uses dword-aligned addresses. Ready stalls and long latencies are varied so that the outstanding cap and request holding are both exercised.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  localparam int HADDR_W = 64;
  localparam int REG_W   = 32;
  localparam int LEN_W   = 9;

  typedef enum logic [2:0] {
    RG_CTRL   = 3'd0,
    RG_MODE   = 3'd1,
    RG_SRC_LO = 3'd2,
    RG_SRC_HI = 3'd3,
    RG_DST    = 3'd4,
    RG_COUNT  = 3'd5
  } reg_idx_e;

  localparam int CTRL_GO_BIT    = 31;
  localparam int CTRL_BUSY_BIT  = 16;
  localparam int CTRL_TGT_LSB   = 24;
  localparam int MODE_SPLIT_BIT = 10;
  localparam int MODE_CHUNK_LSB = 8;
  localparam logic [1:0] TGT_HOST = 2'd1;

  typedef struct packed {
    logic [HADDR_W-1:0] src;
    logic [REG_W-1:0]   dst;
    logic [REG_W-1:0]   count;
    logic [1:0]         chunk_sel;
    logic               split;
    logic [3:0]         max_pend;
  } xfer_cfg_t;

  function automatic logic [LEN_W-1:0] chunk_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    chunk_bytes = 9'd64;
      2'd1:    chunk_bytes = 9'd128;
      default: chunk_bytes = 9'd256;
    endcase
  endfunction
endpackage

// File: rtl/dmr_regs.sv
module dmr_regs
  import dmr_pkg::*;
#(
  parameter int RIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RIDX_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  output xfer_cfg_t         cfg,
  output logic              go,
  output logic [1:0]        go_tgt
);
  logic [REG_W-1:0] src_lo_q, src_hi_q, dst_q, count_q;
  logic [1:0]       tgt_q, sel_q;
  logic             split_q;
  logic [3:0]       maxp_q;
  logic [REG_W-1:0] rdata_q;
  logic             ctrl_hit;

  assign ctrl_hit = reg_we && (reg_addr == RIDX_W'(RG_CTRL));
  assign go       = ctrl_hit && reg_wdata[CTRL_GO_BIT] && !busy;
  assign go_tgt   = reg_wdata[CTRL_TGT_LSB +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_lo_q <= '0; src_hi_q <= '0; dst_q <= '0; count_q <= '0;
      tgt_q <= '0; sel_q <= '0; split_q <= 1'b0; maxp_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RIDX_W'(RG_CTRL):   tgt_q <= reg_wdata[CTRL_TGT_LSB +: 2];
        RIDX_W'(RG_MODE): begin
          split_q <= reg_wdata[MODE_SPLIT_BIT];
          sel_q   <= reg_wdata[MODE_CHUNK_LSB +: 2];
          maxp_q  <= reg_wdata[3:0];
        end
        RIDX_W'(RG_SRC_LO): src_lo_q <= reg_wdata;
        RIDX_W'(RG_SRC_HI): src_hi_q <= reg_wdata;
        RIDX_W'(RG_DST):    dst_q    <= reg_wdata;
        RIDX_W'(RG_COUNT):  count_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (reg_addr)
        RIDX_W'(RG_CTRL):   rdata_q <= {busy, 5'b0, tgt_q, 7'b0, busy, 16'b0};
        RIDX_W'(RG_MODE):   rdata_q <= {21'b0, split_q, sel_q, 4'b0, maxp_q};
        RIDX_W'(RG_SRC_LO): rdata_q <= src_lo_q;
        RIDX_W'(RG_SRC_HI): rdata_q <= src_hi_q;
        RIDX_W'(RG_DST):    rdata_q <= dst_q;
        RIDX_W'(RG_COUNT):  rdata_q <= count_q;
        default:            rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata     = rdata_q;
  assign cfg.src       = {src_hi_q, src_lo_q};
  assign cfg.dst       = dst_q;
  assign cfg.count     = count_q;
  assign cfg.chunk_sel = sel_q;
  assign cfg.split     = split_q;
  assign cfg.max_pend  = maxp_q;

  // R2: the read port shows the busy flag one cycle after it is presented
  a_r2_busy_readback: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == RIDX_W'(RG_CTRL)) |=> (reg_rdata[CTRL_GO_BIT] == $past(busy)));
endmodule

// File: rtl/dmr_req_gen.sv
module dmr_req_gen
  import dmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PEND_MAX = 12,
  parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  xfer_cfg_t          cfg,
  input  logic               rs_done,
  output logic               rq_valid,
  input  logic               rq_ready,
  output logic [HADDR_W-1:0] rq_addr,
  output logic [LEN_W-1:0]   rq_len
);
  logic [HADDR_W-1:0] cur_q, rq_addr_q;
  logic [CNT_W-1:0]   rem_q;
  logic [1:0]         sel_q;
  logic               split_q;
  logic [PEND_W-1:0]  cap_q, pend_q, cap_d;
  logic               rq_valid_q;
  logic [LEN_W-1:0]   rq_len_q, lim, len;
  logic               load;

  always_comb begin
    lim = chunk_bytes(sel_q);
    if (split_q && (sel_q != 2'd0) && (cur_q[6:0] != 7'd0))
      lim = 9'd64 - {3'b0, cur_q[5:0]};
    len = (rem_q < CNT_W'(lim)) ? LEN_W'(rem_q) : lim;
  end

  always_comb begin
    if (cfg.max_pend == 4'd0)                       cap_d = PEND_W'(1);
    else if (int'(cfg.max_pend) > PEND_MAX)         cap_d = PEND_W'(PEND_MAX);
    else                                            cap_d = PEND_W'(cfg.max_pend);
  end

  assign load = (rem_q != '0) && (!rq_valid_q || rq_ready) && (pend_q < cap_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0; rem_q <= '0; sel_q <= '0; split_q <= 1'b0;
      cap_q <= PEND_W'(1); pend_q <= '0;
      rq_valid_q <= 1'b0; rq_addr_q <= '0; rq_len_q <= '0;
    end else if (go) begin
      cur_q   <= cfg.src;
      rem_q   <= CNT_W'(cfg.count);
      sel_q   <= cfg.chunk_sel;
      split_q <= cfg.split;
      cap_q   <= cap_d;
      pend_q  <= '0;
      rq_valid_q <= 1'b0;
    end else begin
      pend_q <= pend_q + PEND_W'(load) - PEND_W'(rs_done && (pend_q != '0));
      if (load) begin
        rq_valid_q <= 1'b1;
        rq_addr_q  <= cur_q;
        rq_len_q   <= len;
        cur_q      <= cur_q + HADDR_W'(len);
        rem_q      <= rem_q - CNT_W'(len);
      end else if (rq_ready) begin
        rq_valid_q <= 1'b0;
      end
    end
  end

  assign rq_valid = rq_valid_q;
  assign rq_addr  = rq_addr_q;
  assign rq_len   = rq_len_q;

  a_r5_pend_cap: assert property (@(posedge clk) disable iff (rst)
    pend_q <= cap_q);
  a_r3_len_range: assert property (@(posedge clk) disable iff (rst)
    rq_valid_q |-> (rq_len_q != '0) && (rq_len_q <= chunk_bytes(sel_q)));
  a_r4_no_cross: assert property (@(posedge clk) disable iff (rst)
    (rq_valid_q && split_q && (sel_q != 2'd0) && (rq_addr_q[6:0] != 7'd0))
      |-> (({3'b0, rq_addr_q[5:0]} + rq_len_q) <= 9'd64));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (rq_valid_q && !rq_ready && !go) |=> rq_valid_q && $stable(rq_addr_q) && $stable(rq_len_q));
endmodule

// File: rtl/dmr_wr_path.sv
module dmr_wr_path #(
  parameter int DATA_W  = 32,
  parameter int SRAM_AW = 10,
  parameter int CNT_W   = 32,
  parameter int BEAT_B  = DATA_W / 8,
  parameter int BB_W    = $clog2(BEAT_B)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [CNT_W-1:0]   dst,
  input  logic [CNT_W-1:0]   count,
  input  logic               rs_valid,
  input  logic [DATA_W-1:0]  rs_data,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DATA_W-1:0]  sram_wdata,
  output logic [BEAT_B-1:0]  sram_be,
  output logic               fin
);
  logic [SRAM_AW-1:0] wptr_q, addr_q;
  logic [CNT_W-1:0]   left_q;
  logic [BB_W-1:0]    tail_q;
  logic               we_q, take;
  logic [DATA_W-1:0]  data_q;
  logic [BEAT_B-1:0]  be_q, be_d;

  assign take = rs_valid && (left_q != '0);
  assign fin  = take && (left_q == CNT_W'(1));

  always_comb begin
    be_d = '1;
    if ((left_q == CNT_W'(1)) && (tail_q != '0))
      be_d = ~({BEAT_B{1'b1}} << tail_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0; left_q <= '0; tail_q <= '0;
      we_q <= 1'b0; addr_q <= '0; data_q <= '0; be_q <= '0;
    end else begin
      we_q <= take && !go;
      if (go) begin
        wptr_q <= dst[BB_W +: SRAM_AW];
        left_q <= (count >> BB_W) + CNT_W'(|count[BB_W-1:0]);
        tail_q <= count[BB_W-1:0];
      end else if (take) begin
        addr_q <= wptr_q;
        data_q <= rs_data;
        be_q   <= be_d;
        wptr_q <= wptr_q + 1'b1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign sram_we    = we_q;
  assign sram_addr  = addr_q;
  assign sram_wdata = data_q;
  assign sram_be    = be_q;

  a_r6_low_lane: assert property (@(posedge clk) disable iff (rst)
    we_q |-> be_q[0] && ($countones(be_q + 1'b1) <= 1));
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (we_q && $past(we_q) && !$past(go, 2)) |-> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/dma_rd_splitter.sv
module dma_rd_splitter
  import dmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SRAM_AW  = 10,
  parameter int CNT_W    = 32,
  parameter int PEND_MAX = 12,
  parameter int RIDX_W   = 3,
  parameter int BE_W     = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [RIDX_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               rq_valid,
  input  logic               rq_ready,
  output logic [63:0]        rq_addr,
  output logic [8:0]         rq_len,
  input  logic               rs_valid,
  input  logic [DATA_W-1:0]  rs_data,
  input  logic               rs_last,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [DATA_W-1:0]  sram_wdata,
  output logic [BE_W-1:0]    sram_be,
  output logic               irq
);
  xfer_cfg_t  cfg;
  logic       go, fin, zero;
  logic [1:0] go_tgt, tgt_q;
  logic       busy_q, irq_q;

  dmr_regs #(.RIDX_W(RIDX_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_q),
    .cfg(cfg), .go(go), .go_tgt(go_tgt)
  );

  dmr_req_gen #(.CNT_W(CNT_W), .PEND_MAX(PEND_MAX)) u_req (
    .clk(clk), .rst(rst), .go(go), .cfg(cfg),
    .rs_done(rs_valid && rs_last && busy_q),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_len(rq_len)
  );

  dmr_wr_path #(.DATA_W(DATA_W), .SRAM_AW(SRAM_AW), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .go(go), .dst(CNT_W'(cfg.dst)), .count(CNT_W'(cfg.count)),
    .rs_valid(rs_valid && busy_q), .rs_data(rs_data),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_be(sram_be), .fin(fin)
  );

  assign zero = (cfg.count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; tgt_q <= '0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (go) begin
        busy_q <= !zero;
        tgt_q  <= go_tgt;
        if (zero) irq_q <= (go_tgt == TGT_HOST);
      end else if (fin) begin
        busy_q <= 1'b0;
        irq_q  <= (tgt_q == TGT_HOST);
      end
    end
  end

  assign irq = irq_q;

  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  a_r7_irq_idle: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !busy_q);
  a_r8_zero_done: assert property (@(posedge clk) disable iff (rst)
    (go && zero) |=> !busy_q && !rq_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !rq_valid);
endmodule

// File: tb/dma_rd_splitter_tb.sv
module dma_rd_splitter_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rq_valid, rq_ready = 1'b0;
  logic [63:0] rq_addr;
  logic [8:0]  rq_len;
  logic        rs_valid = 1'b0, rs_last = 1'b0;
  logic [31:0] rs_data = '0;
  logic        sram_we;
  logic [9:0]  sram_addr;
  logic [31:0] sram_wdata;
  logic [3:0]  sram_be;
  logic        irq;

  dma_rd_splitter u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rq_len(rq_len), .rs_valid(rs_valid), .rs_data(rs_data), .rs_last(rs_last),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_be(sram_be), .irq(irq)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [0:1023];
  logic [63:0] lg_addr [0:63];
  int lg_len [0:63];
  int lg_t [0:63];
  int nlog = 0, ndone = 0, bi = 0, lat = 4, maxout = 0, irqcnt = 0;
  bit stall = 1'b0;

  function automatic logic [31:0] pat(input logic [63:0] a);
    return a[31:0] ^ 32'h5AC3_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (sram_we)
      for (int b = 0; b < 4; b++)
        if (sram_be[b]) mem[sram_addr][8*b +: 8] = sram_wdata[8*b +: 8];
    if (irq) irqcnt++;
    rs_valid = 1'b0; rs_last = 1'b0;
    if (ndone < nlog && cyc >= lg_t[ndone] + lat) begin
      int nb;
      nb = (lg_len[ndone] + 3) / 4;
      rs_valid = 1'b1;
      rs_data  = pat(lg_addr[ndone] + 64'(4 * bi));
      if (bi == nb - 1) begin rs_last = 1'b1; ndone++; bi = 0; end
      else bi++;
    end
    rq_ready = stall ? (cyc % 3 != 0) : 1'b1;
    if (rq_valid && rq_ready) begin
      if (nlog < 64) begin
        lg_addr[nlog] = rq_addr; lg_len[nlog] = int'(rq_len); lg_t[nlog] = cyc;
      end
      nlog++;
      if (nlog - ndone > maxout) maxout = nlog - ndone;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  // runs one transfer; returns whether busy was seen and final control word
  task automatic xfer(input logic [63:0] src, input int dst, input int cnt, input int sel,
                      input bit split, input int maxp, input int tgt, input int l,
                      output bit saw_busy, output logic [31:0] fin_ctrl);
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEE_EEEE;
    nlog = 0; ndone = 0; bi = 0; maxout = 0; irqcnt = 0; lat = l;
    wr(3'd2, src[31:0]); wr(3'd3, src[63:32]); wr(3'd4, 32'(dst)); wr(3'd5, 32'(cnt));
    wr(3'd1, (32'(split) << 10) | (32'(sel) << 8) | 32'(maxp));
    wr(3'd0, 32'h8000_0000 | (32'(tgt) << 24));
    saw_busy = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      rd(3'd0, v);
      if (v[31] && v[16]) saw_busy = 1'b1;
      if (!v[31]) break;
    end
    repeat (3) @(negedge clk);
    rd(3'd0, fin_ctrl);
  endtask

  task automatic check_reqs(input logic [63:0] src, input int cnt, input int sel, input bit split,
                            input string req);
    logic [63:0] a = src;
    int rem = cnt, n = 0, bad = 0, lim;
    while (rem > 0) begin
      lim = (sel == 0) ? 64 : (sel == 1) ? 128 : 256;
      if (split && lim > 64 && a[6:0] != 0) lim = 64 - int'(a[5:0]);
      if (lim > rem) lim = rem;
      if (n < 64 && (lg_addr[n] !== a || lg_len[n] != lim)) begin
        if (bad == 0) $display("FAIL %s request %0d actual=%0d expected=%0d", req, n, lg_len[n], lim);
        bad++;
      end
      a += 64'(lim); rem -= lim; n++;
    end
    checks++;
    if (bad != 0) fails++;
    chk(nlog == n, req, nlog, n);
  endtask

  task automatic check_mem(input logic [63:0] src, input int dst, input int cnt, input string req);
    int nb = (cnt + 3) / 4, bad = 0, w = dst / 4;
    logic [31:0] e, m;
    for (int i = 0; i < nb; i++) begin
      m = (i == nb - 1 && cnt % 4 != 0) ? ((32'd1 << (8 * (cnt % 4))) - 1) : 32'hFFFF_FFFF;
      e = (pat(src + 64'(4 * i)) & m) | (32'hEEEE_EEEE & ~m);
      if (mem[w + i] !== e) begin
        if (bad == 0) $display("FAIL %s word %0d actual=%0d expected=%0d", req, i, mem[w + i], e);
        bad++;
      end
    end
    checks++;
    if (bad != 0) fails++;
    chk(mem[w + nb] === 32'hEEEE_EEEE, req, mem[w + nb], 32'hEEEE_EEEE);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(rq_valid === 1'b0, "R1 rq_valid", rq_valid, 0);
    chk(sram_we === 1'b0 && irq === 1'b0, "R1 we/irq", {sram_we, irq}, 0);
    rd(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'd1, v); chk(v == 0, "R1 mode", v, 0);
  endtask

  task automatic t_plain;
    bit sb; logic [31:0] fc;
    stall = 1'b1;
    xfer(64'h1_0000_1000, 32'h100, 200, 0, 1'b0, 4, 1, 4, sb, fc);
    check_reqs(64'h1_0000_1000, 200, 0, 1'b0, "R3 plain 64B");
    check_mem(64'h1_0000_1000, 32'h100, 200, "R6 plain data");
    chk(sb, "R2 busy seen", sb, 1);
    chk(fc[31] == 1'b0 && fc[16] == 1'b0, "R2 start self-clear", fc[31], 0);
    chk(irqcnt == 1, "R7 irq pulse", irqcnt, 1);
    stall = 1'b0;
  endtask

  task automatic t_split;
    bit sb; logic [31:0] fc;
    xfer(64'h1030, 32'h40, 301, 1, 1'b1, 12, 1, 5, sb, fc);
    check_reqs(64'h1030, 301, 1, 1'b1, "R4 split 128B");
    check_mem(64'h1030, 32'h40, 301, "R6 partial tail");
  endtask

  task automatic t_nosplit;
    bit sb; logic [31:0] fc;
    xfer(64'h1030, 32'h40, 301, 1, 1'b0, 12, 1, 5, sb, fc);
    check_reqs(64'h1030, 301, 1, 1'b0, "R3 unaligned no split");
    check_mem(64'h1030, 32'h40, 301, "R6 no split data");
  endtask

  task automatic t_big;
    bit sb; logic [31:0] fc;
    xfer(64'h2040, 32'h0, 700, 2, 1'b1, 2, 1, 3, sb, fc);
    check_reqs(64'h2040, 700, 2, 1'b1, "R4 split 256B");
    check_mem(64'h2040, 32'h0, 700, "R6 256B data");
    xfer(64'h2040, 32'h0, 699, 3, 1'b0, 2, 1, 3, sb, fc);
    check_reqs(64'h2040, 699, 3, 1'b0, "R3 sel3 as 256B");
  endtask

  task automatic t_cap;
    bit sb; logic [31:0] fc;
    xfer(64'h4000, 32'h100, 2048, 0, 1'b0, 15, 1, 60, sb, fc);
    chk(maxout == 12, "R5 clamp to 12", maxout, 12);
    check_mem(64'h4000, 32'h100, 2048, "R6 long data");
    xfer(64'h4000, 32'h100, 1024, 0, 1'b0, 3, 1, 40, sb, fc);
    chk(maxout == 3, "R5 cap 3", maxout, 3);
    xfer(64'h4000, 32'h100, 256, 0, 1'b0, 0, 1, 20, sb, fc);
    chk(maxout == 1, "R5 zero as 1", maxout, 1);
    check_reqs(64'h4000, 256, 0, 1'b0, "R5 zero cap reqs");
  endtask

  task automatic t_zero;
    bit sb; logic [31:0] fc;
    xfer(64'h5000, 32'h80, 0, 1, 1'b0, 4, 1, 4, sb, fc);
    chk(nlog == 0, "R8 no requests", nlog, 0);
    chk(irqcnt == 1, "R8 irq", irqcnt, 1);
    chk(fc[31] == 1'b0, "R8 idle", fc[31], 0);
    chk(mem[32] === 32'hEEEE_EEEE, "R8 no write", mem[32], 32'hEEEE_EEEE);
  endtask

  task automatic t_notgt;
    bit sb; logic [31:0] fc;
    xfer(64'h6000, 32'h80, 96, 0, 1'b0, 4, 2, 4, sb, fc);
    chk(irqcnt == 0, "R7 no irq for tgt 2", irqcnt, 0);
    chk(fc[31] == 1'b0, "R7 completes", fc[31], 0);
    check_mem(64'h6000, 32'h80, 96, "R7 data tgt 2");
    xfer(64'h6000, 32'h80, 0, 0, 1'b0, 4, 0, 4, sb, fc);
    chk(irqcnt == 0, "R8 zero no irq tgt 0", irqcnt, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_split();
    t_nosplit();
    t_big();
    t_cap();
    t_zero();
    t_notgt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule